// File: doc/BRIEF.md
# Data-Space Operand Address Generator

This block turns one decoded instruction into a request against the 256-byte data space. It takes an opcode byte, the byte that follows it, a mode select and the current values of the two indirect pointer registers. It produces a registered memory request carrying the effective address, a read or write flag and write data. Immediate-mode instructions take their operand from program memory. For these the block still emits one request, marked as having no data-space access, so that every accepted instruction yields a response.

Single-bit set and clear run as a read-modify-write on the addressed byte. The block first issues a read request. It captures the returned byte one cycle after the read handshake and forces one bit to the requested value. It then issues a write request to the same address. The other seven bits are written back unchanged.

Both sides use valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. A request held under back-pressure keeps all its fields stable until it is taken. `in_ready` may follow `req_ready` in the same cycle when a plain request is draining. It stays low for the whole of a bit operation. Read data from the memory must appear on `mem_rdata` in the cycle after the read request is accepted.

Top module: `dspace_agu`

## Requirements
- R1: After reset, `req_valid` is low and `in_ready` is high while `req_ready` is high.
- R2: Direct mode (mode code 0) issues one read request whose address equals the operand byte. `req_valid` rises in the cycle after the instruction is accepted.
- R3: Short-direct mode (mode code 1) issues one read request to address 80h plus opcode bits [1:0]. The four possible addresses are 80h, 81h, 82h and 83h.
- R4: Indirect mode (mode code 2) issues a read request to the X pointer value when opcode bit 4 is 0, and to the Y pointer value when it is 1. The pointer is sampled at acceptance, so later changes to the pointer inputs have no effect on that request.
- R5: Mode code 4, and the unused codes 5 to 7, issue one request with `req_none` high, address 00h and `req_write` low. The memory is not touched.
- R6: Bit mode (mode code 3) issues a read request to the operand address, leaves one idle cycle after the read handshake, and then issues a write request to the same address.
- R7: The written byte equals the byte read, except for bit number opcode[7:5]. That bit becomes 1 when opcode bit 3 is 1 and 0 when opcode bit 3 is 0.
- R8: While `req_valid` is high and `req_ready` is low, the request and all its fields stay unchanged in the next cycle.
- R9: `in_ready` is low from the acceptance of a bit operation until its write is accepted. It is also low while a plain request is waiting and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted |
| in_mode | input | 3 | Addressing mode code |
| in_opcode | input | 8 | Opcode byte |
| in_operand | input | 8 | Byte following the opcode |
| ptr_x | input | 8 | Current X pointer value |
| ptr_y | input | 8 | Current Y pointer value |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory can take the request |
| req_addr | output | 8 | Effective data-space address |
| req_write | output | 1 | 1 for write, 0 for read |
| req_wdata | output | 8 | Write data for bit operations |
| req_none | output | 1 | Request carries no data-space access |
| mem_rdata | input | 8 | Read data, valid the cycle after a read handshake |

## Verification
The hardest case to reach is a bit operation that meets back-pressure at both of its phases. It must also be followed at once by another instruction waiting at the input. Only that combination shows that the write is held stable, that the idle gap is exact, and that no new instruction slips in during the sequence. The bench drives `req_ready` from a random source that drops about a third of the time. It keeps a new instruction always pending on the input. Over a long random run, these stalls land on the read phase, on the write phase and on the drain of plain requests. A behavioural model predicts every output on every cycle.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_DIRECT = 3'd0,
    MD_SHORT  = 3'd1,
    MD_INDIR  = 3'd2,
    MD_BIT    = 3'd3,
    MD_IMM    = 3'd4
  } agu_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_BRD,
    ST_BWAIT,
    ST_BWR
  } agu_state_e;
endpackage

// File: rtl/agu_addr_sel.sv
`timescale 1ns/1ps
module agu_addr_sel
  import agu_pkg::*;
#(
  parameter int AW         = 8,
  parameter int SHORT_BASE = 128,
  parameter int SHORT_W    = 2
) (
  input  logic [MODE_W-1:0]  mode,
  input  logic [SHORT_W-1:0] short_sel,
  input  logic               ind_sel,
  input  logic [AW-1:0]      operand,
  input  logic [AW-1:0]      ptr_x,
  input  logic [AW-1:0]      ptr_y,
  output logic [AW-1:0]      addr,
  output logic               none,
  output logic               bitop
);
  localparam logic [AW-1:0] BASE_A = AW'(SHORT_BASE);

  always_comb begin
    addr  = '0;
    none  = 1'b0;
    bitop = 1'b0;
    case (mode)
      MD_DIRECT: addr = operand;
      MD_SHORT:  addr = BASE_A + AW'(short_sel);
      MD_INDIR:  addr = ind_sel ? ptr_y : ptr_x;
      MD_BIT: begin
        addr  = operand;
        bitop = 1'b1;
      end
      default:   none = 1'b1;
    endcase
  end
endmodule

// File: rtl/agu_bit_merge.sv
`timescale 1ns/1ps
module agu_bit_merge #(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [IW-1:0] bidx,
  input  logic          setb,
  output logic [DW-1:0] dout
);
  for (genvar gi = 0; gi < DW; gi++) begin : g_bit
    assign dout[gi] = (bidx == IW'(gi)) ? setb : din[gi];
  end
endmodule

// File: rtl/agu_seq.sv
`timescale 1ns/1ps
module agu_seq
  import agu_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] dec_addr,
  input  logic          dec_none,
  input  logic          dec_bitop,
  input  logic [IW-1:0] bidx_in,
  input  logic          setb_in,
  input  logic [DW-1:0] merged,
  input  logic          req_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic          req_write,
  output logic [DW-1:0] req_wdata,
  output logic          req_none,
  output logic [IW-1:0] bidx_q,
  output logic          setb_q
);
  agu_state_e st;
  logic accept;

  assign in_ready = (st == ST_IDLE) || ((st == ST_HOLD) && req_ready);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_write <= 1'b0;
      req_wdata <= '0;
      req_none  <= 1'b0;
      bidx_q    <= '0;
      setb_q    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE, ST_HOLD: begin
          if ((st == ST_HOLD) && req_ready && !accept) begin
            st        <= ST_IDLE;
            req_valid <= 1'b0;
          end
          if (accept) begin
            req_valid <= 1'b1;
            req_addr  <= dec_addr;
            req_none  <= dec_none;
            req_write <= 1'b0;
            req_wdata <= '0;
            bidx_q    <= bidx_in;
            setb_q    <= setb_in;
            st        <= dec_bitop ? ST_BRD : ST_HOLD;
          end
        end
        ST_BRD: begin
          if (req_ready) begin
            st        <= ST_BWAIT;
            req_valid <= 1'b0;
          end
        end
        ST_BWAIT: begin
          st        <= ST_BWR;
          req_valid <= 1'b1;
          req_write <= 1'b1;
          req_wdata <= merged;
        end
        ST_BWR: begin
          if (req_ready) begin
            st        <= ST_IDLE;
            req_valid <= 1'b0;
            req_write <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dspace_agu.sv
`timescale 1ns/1ps
module dspace_agu
  import agu_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int OPW        = 8,
  parameter int SHORT_BASE = 128,
  parameter int SHORT_LSB  = 0,
  parameter int SHORT_W    = 2,
  parameter int IND_BIT    = 4,
  parameter int SET_BIT    = 3,
  parameter int BIDX_LSB   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MODE_W-1:0] in_mode,
  input  logic [OPW-1:0]    in_opcode,
  input  logic [AW-1:0]     in_operand,
  input  logic [AW-1:0]     ptr_x,
  input  logic [AW-1:0]     ptr_y,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  output logic              req_write,
  output logic [DW-1:0]     req_wdata,
  output logic              req_none,
  input  logic [DW-1:0]     mem_rdata
);
  localparam int IW = $clog2(DW);

  logic [AW-1:0] dec_addr;
  logic          dec_none, dec_bitop;
  logic [IW-1:0] bidx_q;
  logic          setb_q;
  logic [DW-1:0] merged;
  logic          unused_opcode_bit;

  assign unused_opcode_bit = in_opcode[2];

  agu_addr_sel #(.AW(AW), .SHORT_BASE(SHORT_BASE), .SHORT_W(SHORT_W)) u_sel (
    .mode      (in_mode),
    .short_sel (in_opcode[SHORT_LSB +: SHORT_W]),
    .ind_sel   (in_opcode[IND_BIT]),
    .operand   (in_operand),
    .ptr_x     (ptr_x),
    .ptr_y     (ptr_y),
    .addr      (dec_addr),
    .none      (dec_none),
    .bitop     (dec_bitop)
  );

  agu_bit_merge #(.DW(DW)) u_merge (
    .din  (mem_rdata),
    .bidx (bidx_q),
    .setb (setb_q),
    .dout (merged)
  );

  agu_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .dec_addr  (dec_addr),
    .dec_none  (dec_none),
    .dec_bitop (dec_bitop),
    .bidx_in   (in_opcode[BIDX_LSB +: IW]),
    .setb_in   (in_opcode[SET_BIT]),
    .merged    (merged),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .req_none  (req_none),
    .bidx_q    (bidx_q),
    .setb_q    (setb_q)
  );
endmodule

// File: rtl/agu_checker.sv
`timescale 1ns/1ps
module agu_checker #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          req_write,
  input logic [DW-1:0] req_wdata,
  input logic          req_none
);
  AST_ACCEPT_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> req_valid); // R2

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write)
      && $stable(req_wdata) && $stable(req_none)); // R8

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && !$past(req_valid)
      |-> $past(req_valid && req_ready && !req_write, 2) && ($past(req_addr, 2) == req_addr)); // R6

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> !in_ready); // R9

  AST_IMM_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_none |-> !req_write && (req_addr == '0)); // R5
endmodule

bind dspace_agu agu_checker u_agu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_write (req_write),
  .req_wdata (req_wdata),
  .req_none  (req_none)
);

// File: tb/dspace_agu_test.sv
`timescale 1ns/1ps
module dspace_agu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_mode = '0;
  logic [7:0] in_opcode = '0, in_operand = '0, ptr_x = '0, ptr_y = '0;
  logic       req_valid, req_write, req_none;
  logic       req_ready = 1'b1;
  logic [7:0] req_addr, req_wdata;
  logic [7:0] mem_rdata;

  int  compared = 0, mismatched = 0;
  bit  done = 1'b0, bp_en = 1'b0;

  always #10 clk = ~clk;

  dspace_agu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_opcode(in_opcode), .in_operand(in_operand),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_none(req_none), .mem_rdata(mem_rdata)
  );

  // Synchronous memory model
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] rdata_q = '0;
  assign mem_rdata = rdata_q;
  initial for (int i = 0; i < 256; i++) begin
    mem[i] = 8'(i * 37 + 5);
    ref_mem[i] = 8'(i * 37 + 5);
  end
  always @(posedge clk)
    if (req_valid && req_ready && !req_none) begin
      if (req_write) mem[req_addr] <= req_wdata;
      else rdata_q <= mem[req_addr];
    end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // Behavioural reference model, compared just before every rising edge
  bit         exp_v = 0, exp_w = 0, exp_none = 0, bit_busy = 0, wait_flag = 0, stalled_prev = 0;
  logic [7:0] exp_addr = 0, exp_wd = 0, pend_wd = 0;
  string      exp_tag = "R2";

  initial begin
    forever begin
      bit exp_rdy, fire_in, fire_out;
      string t;
      @(negedge clk); #9;
      if (!rst_n) continue;
      t = stalled_prev ? "R8" : exp_tag;
      exp_rdy = !bit_busy && (!exp_v || req_ready);
      chk(req_valid == exp_v, t, "req_valid", req_valid, exp_v);
      chk(in_ready == exp_rdy, "R9", "in_ready", in_ready, exp_rdy);
      if (exp_v) begin
        chk(req_addr == exp_addr, t, "req_addr", req_addr, exp_addr);
        chk(req_write == exp_w, t, "req_write", req_write, exp_w);
        chk(req_none == exp_none, t, "req_none", req_none, exp_none);
        if (exp_w) chk(req_wdata == exp_wd, stalled_prev ? "R8" : "R7", "req_wdata", req_wdata, exp_wd);
      end
      fire_out = exp_v && req_ready;
      fire_in  = in_valid && exp_rdy;
      stalled_prev = exp_v && !req_ready;
      if (wait_flag) begin
        exp_v = 1; exp_w = 1; exp_wd = pend_wd; wait_flag = 0; exp_tag = "R6";
      end else if (fire_out) begin
        if (bit_busy && !exp_w) wait_flag = 1;
        else if (exp_w) begin
          ref_mem[exp_addr] = exp_wd;
          bit_busy = 0;
        end
        exp_v = 0;
      end
      if (fire_in) begin
        exp_v = 1; exp_w = 0; exp_none = 0;
        case (in_mode)
          3'd0: begin exp_addr = in_operand; exp_tag = "R2"; end
          3'd1: begin exp_addr = 8'h80 + 8'(in_opcode[1:0]); exp_tag = "R3"; end
          3'd2: begin exp_addr = in_opcode[4] ? ptr_y : ptr_x; exp_tag = "R4"; end
          3'd3: begin
            exp_addr = in_operand; exp_tag = "R6"; bit_busy = 1;
            if (in_opcode[3]) pend_wd = ref_mem[in_operand] | (8'h1 << in_opcode[7:5]);
            else pend_wd = ref_mem[in_operand] & ~(8'h1 << in_opcode[7:5]);
          end
          default: begin exp_addr = 0; exp_none = 1; exp_tag = "R5"; end
        endcase
      end
    end
  end

  // Back-pressure source
  initial forever begin
    @(negedge clk); #2;
    req_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;
  end

  // Offer one instruction; entered and left at negedge + 2
  task automatic issue(input logic [2:0] m, input logic [7:0] op, input logic [7:0] opd);
    in_mode = m; in_opcode = op; in_operand = opd;
    ptr_x = 8'($urandom); ptr_y = 8'($urandom); in_valid = 1'b1;
    while (1) begin
      bit acc;
      #7 acc = in_ready;
      @(negedge clk); #2;
      if (acc) break;
    end
    in_valid = 1'b0;
    ptr_x = 8'($urandom); ptr_y = 8'($urandom); in_opcode = 8'($urandom); in_operand = 8'($urandom);
  endtask

  task automatic gap(input int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #9;
    chk(req_valid == 1'b0, "R1", "reset req_valid", req_valid, 0);
    chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    #3;
    // R2 direct, boundary addresses
    issue(3'd0, 8'h5a, 8'h00); issue(3'd0, 8'h00, 8'hff);
    issue(3'd0, 8'hff, 8'h7f); gap(2); issue(3'd0, 8'h11, 8'h80);
    // R3 short-direct, all four selectors
    for (int s = 0; s < 4; s++) issue(3'd1, {6'($urandom), 2'(s)}, 8'($urandom));
    // R4 indirect via X and via Y
    issue(3'd2, 8'h00, 8'h33); issue(3'd2, 8'h10, 8'h44);
    issue(3'd2, 8'hef, 8'h00); issue(3'd2, 8'hff, 8'h00);
    // R5 immediate and unused codes
    for (int m = 4; m < 8; m++) issue(3'(m), 8'($urandom), 8'($urandom));
    // R6 R7 bit set and clear on every bit position
    for (int b = 0; b < 8; b++) begin
      issue(3'd3, {3'(b), 1'b0, 1'b1, 3'b000}, 8'h80);
      issue(3'd3, {3'(b), 1'b1, 1'b0, 3'b111}, 8'h80);
    end
    issue(3'd3, 8'hf8, 8'h00); issue(3'd3, 8'h10, 8'hff);
    issue(3'd0, 8'h00, 8'h80);
    gap(3);
    // R8 R9 random mix under back-pressure
    bp_en = 1'b1;
    for (int k = 0; k < 400; k++) issue(3'($urandom % 8), 8'($urandom), 8'($urandom % 16));
    bp_en = 1'b0;
    gap(10);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
      chk(bad == 0, "R7", "memory bytes differing", bad, 0);
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      summary();
      $finish;
    end
  end
endmodule